// File: doc/BRIEF.md
# E1 Byte-Interleaved Backplane Multiplexer

This block merges four framed E1 receive channels, each carrying 2.048 Mb/s, onto one serial backplane line that runs four times as fast, at 8.192 Mb/s. One clock cycle of the shared system clock is one output bit period. Each channel supplies bytes through a parallel write port with a time-slot address. Each channel owns two 32-slot frame banks. Writes always land in the back bank. The front bank is shifted out MSB first, a whole byte at a time, and the channels take turns: channel 0, 1, 2, 3 for slot 0, then the same four for slot 1, and so on. A multiplexed frame is therefore 128 bytes, or 1024 bit periods, long.

A frame pulse from the backplane restarts the output frame. Each channel has a configuration bit that asks for the pulse to be ignored. The pulse is ignored only when every channel sets this bit. If even one channel leaves it clear, the pulse restarts the frame for all channels. Without a pulse, the position counters run freely and wrap after 1024 bit periods. At every frame start, whether from a pulse or from a wrap, the two banks of every channel trade roles. A frame-marker output is high during the first bit period of each frame.

Top module: `e1mux_top`

## Requirements
- R1: After reset, the position is channel 0, slot 0, MSB, and the front bank is bank 0. The banks reset to all zeros, so fp_out is 1 and sd_out is 0 until the first clock edge after reset is released.
- R2: Each output byte is sent MSB first, one bit per clock. Channels follow in the order 0, 1, 2, 3 within a time slot, and slots follow in the order 0 to 31. The bit on sd_out is bit (7 - b) of the front-bank byte for that channel and slot, where b is the bit position 0 to 7 within the byte.
- R3: When no pulse is honoured, the position advances by one each clock and wraps from the last position (slot 31, channel 3, bit 7) to slot 0, channel 0, bit 0. fp_out is 1 only in the bit period at position zero.
- R4: When fp_in is high at a clock edge and the pulse is honoured, the next bit period is channel 0, slot 0, MSB, and fp_out is 1 in that period. This holds at any position.
- R5: fp_ignore[c] = 1 asks for the pulse to be ignored for channel c. The pulse is ignored only when all four of these bits are 1. A pulse that is ignored has no effect on the position or on fp_out.
- R6: Every frame start swaps front and back banks in all channels. This happens on an honoured pulse, including one that arrives while the position is already zero, and on a wrap. Writes never change front-bank contents, so the frame being sent cannot be disturbed.
- R7: When wr_en[c] is 1 at a clock edge, wr_data byte c is stored into time slot wr_slot field c of the back bank of channel c. The back bank is the one that is not in front at that edge. Writes to the four channels are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one output bit period per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_in | input | 1 | Backplane frame pulse |
| fp_ignore | input | 4 | Per-channel request to ignore fp_in (1 = ignore) |
| wr_en | input | 4 | Per-channel byte write strobe |
| wr_slot | input | 20 | Per-channel slot address, 5 bits each, channel c in bits [5c+4:5c] |
| wr_data | input | 32 | Per-channel byte, channel c in bits [8c+7:8c] |
| sd_out | output | 1 | Multiplexed serial data |
| fp_out | output | 1 | High in the first bit period of each output frame |

## Verification
The bench builds the block with its default parameters: four channels, 32 slots and 8-bit bytes. With these values a frame is 1024 cycles long, so the run covers about ten whole frames. That is enough to reach free-running wraps, bank swaps triggered by both a wrap and a pulse, and pulses that arrive in the middle of a byte or while the position is already zero. It also sweeps the ignore-bit patterns, from all ignored to a single channel honouring the pulse, with random writes landing in the back banks throughout.

// File: rtl/e1mux_pkg.sv
package e1mux_pkg;
    localparam int DEF_NCH   = 4;
    localparam int DEF_SLOTS = 32;
    localparam int DEF_BW    = 8;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/e1mux_chbuf.sv
module e1mux_chbuf
    import e1mux_pkg::*;
#(
    parameter int SLOTS = DEF_SLOTS,
    parameter int BW    = DEF_BW,
    localparam int SW   = idx_w(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          front_sel,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [BW-1:0] wr_data,
    input  logic [SW-1:0] rd_slot,
    output logic [BW-1:0] rd_byte
);
    typedef struct packed {
        logic [1:0][SLOTS-1:0][BW-1:0] mem;
    } buf_t;

    buf_t buf_d, buf_q;
    logic back_sel;

    assign back_sel = ~front_sel;

    always_comb begin
        buf_d = buf_q;
        if (wr_en && (int'(wr_slot) < SLOTS)) begin
            buf_d.mem[back_sel][wr_slot] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    always_comb begin
        rd_byte = '0;
        if (int'(rd_slot) < SLOTS) begin
            rd_byte = buf_q.mem[front_sel][rd_slot];
        end
    end

    // R6: the front bank cannot change while the bank selection holds
    assert_front_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(front_sel) |-> $stable(buf_q.mem[front_sel]));

    // R7: a write reaches the back bank at the addressed slot
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_slot) < SLOTS)) |=> (buf_q.mem[$past(back_sel)][$past(wr_slot)] == $past(wr_data)));
endmodule

// File: rtl/e1mux_timing.sv
module e1mux_timing
    import e1mux_pkg::*;
#(
    parameter int NCH   = DEF_NCH,
    parameter int SLOTS = DEF_SLOTS,
    parameter int BW    = DEF_BW,
    localparam int CW   = idx_w(NCH),
    localparam int SW   = idx_w(SLOTS),
    localparam int BIW  = idx_w(BW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fp_in,
    input  logic           honour,
    output logic [BIW-1:0] bit_idx,
    output logic [CW-1:0]  ch_idx,
    output logic [SW-1:0]  slot_idx,
    output logic           bank,
    output logic           at_first,
    output logic           at_last
);
    typedef struct packed {
        logic [BIW-1:0] bitp;
        logic [CW-1:0]  ch;
        logic [SW-1:0]  slot;
        logic           bank;
    } pos_t;

    pos_t pos_d, pos_q;
    logic bit_end, ch_end, slot_end, restart, start;

    assign bit_end  = (pos_q.bitp == BIW'(BW - 1));
    assign ch_end   = (pos_q.ch   == CW'(NCH - 1));
    assign slot_end = (pos_q.slot == SW'(SLOTS - 1));
    assign restart  = fp_in && honour;
    assign start    = restart || (bit_end && ch_end && slot_end);

    always_comb begin
        pos_d = pos_q;
        if (start) begin
            pos_d.bitp = '0;
            pos_d.ch   = '0;
            pos_d.slot = '0;
            pos_d.bank = ~pos_q.bank;
        end else if (!bit_end) begin
            pos_d.bitp = pos_q.bitp + 1'b1;
        end else begin
            pos_d.bitp = '0;
            if (!ch_end) begin
                pos_d.ch = pos_q.ch + 1'b1;
            end else begin
                pos_d.ch   = '0;
                pos_d.slot = pos_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign bit_idx  = pos_q.bitp;
    assign ch_idx   = pos_q.ch;
    assign slot_idx = pos_q.slot;
    assign bank     = pos_q.bank;
    assign at_first = (pos_q.bitp == '0) && (pos_q.ch == '0) && (pos_q.slot == '0);
    assign at_last  = bit_end && ch_end && slot_end;

    // R4: an honoured pulse restarts at the frame origin
    assert_restart_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_in && honour) |=> (at_first && (bank != $past(bank))));

    // R3: the last position wraps to the origin when no pulse is honoured
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fp_in && honour) && at_last) |=> at_first);

    // R2: bits advance one per clock inside a byte
    assert_bit_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fp_in && honour) && !bit_end) |=> ((bit_idx == $past(bit_idx) + 1'b1) && $stable(ch_idx) && $stable(slot_idx)));

    // R6: banks only swap at a frame start
    assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(fp_in && honour) && !at_last) |=> $stable(bank));
endmodule

// File: rtl/e1mux_top.sv
module e1mux_top
    import e1mux_pkg::*;
#(
    parameter int NCH   = DEF_NCH,
    parameter int SLOTS = DEF_SLOTS,
    parameter int BW    = DEF_BW,
    localparam int SW   = idx_w(SLOTS),
    localparam int CW   = idx_w(NCH),
    localparam int BIW  = idx_w(BW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_in,
    input  logic [NCH-1:0]    fp_ignore,
    input  logic [NCH-1:0]    wr_en,
    input  logic [NCH*SW-1:0] wr_slot,
    input  logic [NCH*BW-1:0] wr_data,
    output logic              sd_out,
    output logic              fp_out
);
    logic           honour;
    logic [BIW-1:0] bit_idx;
    logic [CW-1:0]  ch_idx;
    logic [SW-1:0]  slot_idx;
    logic           bank;
    logic           at_first;
    logic           at_last;
    logic [NCH-1:0][BW-1:0] ch_bytes;
    logic [BW-1:0]  cur_byte;

    // any channel that leaves its ignore bit clear makes the pulse count
    assign honour = ~&fp_ignore;

    e1mux_timing #(.NCH(NCH), .SLOTS(SLOTS), .BW(BW)) u_tim (
        .clk      (clk),
        .rst_n    (rst_n),
        .fp_in    (fp_in),
        .honour   (honour),
        .bit_idx  (bit_idx),
        .ch_idx   (ch_idx),
        .slot_idx (slot_idx),
        .bank     (bank),
        .at_first (at_first),
        .at_last  (at_last)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        e1mux_chbuf #(.SLOTS(SLOTS), .BW(BW)) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .front_sel (bank),
            .wr_en     (wr_en[c]),
            .wr_slot   (wr_slot[c*SW +: SW]),
            .wr_data   (wr_data[c*BW +: BW]),
            .rd_slot   (slot_idx),
            .rd_byte   (ch_bytes[c])
        );
    end

    always_comb begin
        cur_byte = '0;
        if (int'(ch_idx) < NCH) begin
            cur_byte = ch_bytes[ch_idx];
        end
    end

    assign sd_out = cur_byte[BIW'(BW - 1) - bit_idx];
    assign fp_out = at_first;

    // R5: a pulse while every channel asks to ignore it changes nothing
    assert_ignore_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((&fp_ignore) && fp_in && !at_last) |=> !fp_out);

    // R5: one channel honouring is enough to restart the frame
    assert_any_honours_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&fp_ignore) && fp_in) |=> fp_out);
endmodule

// File: tb/sim_e1mux_top.sv
module sim_e1mux_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fp_in = 1'b0;
    logic [3:0]  fp_ignore = 4'hF;
    logic [3:0]  wr_en = 4'h0;
    logic [19:0] wr_slot = '0;
    logic [31:0] wr_data = '0;
    logic        sd_out;
    logic        fp_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string req = "R1";

    int mem [4][2][32];
    int cnt = 0;
    int bank = 0;

    always #5 clk = ~clk;

    e1mux_top u0 (
        .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .fp_ignore(fp_ignore),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
        .sd_out(sd_out), .fp_out(fp_out)
    );

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic compare();
        int b, ch, sl;
        logic exp_sd, exp_fp;
        b  = cnt % 8;
        ch = (cnt / 8) % 4;
        sl = cnt / 32;
        exp_sd = logic'((mem[ch][bank][sl] >> (7 - b)) & 1);
        exp_fp = (cnt == 0);
        checks++;
        if (sd_out !== exp_sd) begin
            fails++;
            $display("FAIL %s sd_out pos %0d: actual %b expected %b", req, cnt, sd_out, exp_sd);
        end
        checks++;
        if (fp_out !== exp_fp) begin
            fails++;
            $display("FAIL %s fp_out pos %0d: actual %b expected %b", req, cnt, fp_out, exp_fp);
        end
    endtask

    // predict the state after the next rising edge from the inputs now driven
    task automatic model_update();
        bit start;
        start = (fp_in && !(&fp_ignore)) || (cnt == 1023);
        for (int c = 0; c < 4; c++) begin
            if (wr_en[c]) mem[c][1 - bank][wr_slot[c*5 +: 5]] = int'(wr_data[c*8 +: 8]);
        end
        if (start) begin
            cnt = 0;
            bank = 1 - bank;
        end else begin
            cnt++;
        end
    endtask

    // one cycle: check outputs, drive new inputs, predict
    task automatic step(input bit fp, input logic [3:0] ign, input int wprob);
        @(negedge clk);
        compare();
        fp_in = fp;
        fp_ignore = ign;
        for (int c = 0; c < 4; c++) begin
            wr_en[c] = ($urandom_range(99) < wprob);
            wr_slot[c*5 +: 5] = 5'($urandom_range(31));
            wr_data[c*8 +: 8] = 8'($urandom_range(255));
        end
        model_update();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual hung expected finish");
        finish_up();
    end

    initial begin
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 2; k++)
                for (int s = 0; s < 32; s++) mem[c][k][s] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        req = "R1";
        compare();
        rst_n = 1'b1;
        compare();
        model_update();

        // R7: fill back banks while the first frame runs
        req = "R7";
        for (int i = 0; i < 1100; i++) step(0, 4'hF, 60);
        // R2: byte order on frame carrying written data
        req = "R2";
        for (int i = 0; i < 1100; i++) step(0, 4'hF, 40);
        // R5: pulses with every ignore bit set
        req = "R5";
        for (int i = 0; i < 1500; i++) step((i % 137) == 5, 4'hF, 30);
        // R4: single channel honours pulses at odd positions
        req = "R4";
        for (int i = 0; i < 2500; i++) step((i % 613) == 77, 4'b1110, 30);
        // R4: another single honouring channel, pulse held several cycles
        for (int i = 0; i < 1500; i++) step((i % 700) < 3, 4'b0111, 30);
        // R6: heavy writes, pulse when already at origin swaps again
        req = "R6";
        for (int i = 0; i < 1500; i++) step((i == 400) || (i == 401) || (i == 900), 4'b1011, 90);
        // R3: free run across several wraps
        req = "R3";
        for (int i = 0; i < 2200; i++) step(0, 4'hF, 20);
        @(negedge clk);
        compare();
        finish_up();
    end
endmodule